// File: doc/BRIEF.md
# Serial Controller Host Register and Modem-Control Front End

This block is the processor-facing side of a programmable serial communications controller. The host reaches it through an active-low chip select, separate active-low read and write strobes, and a select line. The select line steers each access either to the control/status side or to the data side. Strobes are synchronised to the master clock and edge-detected, so each assertion acts once. After reset the first control write becomes the mode word. Every later control write is a command, until a command asks for a return to mode entry.

The command word drives the active-low data-terminal-ready and request-to-send pins. It also drives a transmit-enable qualifier, which requires the active-low clear-to-send input as well. On the data side the block holds a one-character transmit buffer and a one-character receive buffer. Both talk to the serial shift engines through simple handshake ports. An eight-bit status word combines buffer state, sticky error flags, the sync/break indication and the data-set-ready pin.

Top module: `usart_host_if`

## Requirements
- R1: While `rst_n` is low, and after it rises, the block shows a cleared state: `dtr_n`=1, `rts_n`=1, `tx_enable`=0, `rx_ready`=0, `tx_valid`=0, `oe_n`=1, `dout`=0, error flags clear, and it waits for a mode word.
- R2: A read is active only while `cs_n` and `rd_n` are both low. A write acts only when `cs_n` and `wr_n` are both low. A strobe with `cs_n` high changes nothing.
- R3: `oe_n` is low exactly while a read is active, after the synchroniser delay. Whenever `oe_n` is high, `dout` is 0.
- R4: A read with `sel_ctl`=1 returns the status word. A read with `sel_ctl`=0 returns the receive buffer.
- R5: The first control write (`sel_ctl`=1) after reset is stored as the mode word on `mode_word`. Later control writes are commands and leave `mode_word` unchanged.
- R6: Command bit 1 set drives `dtr_n` low. Command bit 5 set drives `rts_n` low. Clearing either bit returns its pin high.
- R7: `tx_enable` is 1 only when command bit 0 is set and `cts_n` is low.
- R8: A data write (`sel_ctl`=0) loads `tx_data` and raises `tx_valid`. A `tx_accept` pulse lowers `tx_valid`. Status bit 0 reads 1 exactly when the transmit buffer is empty.
- R9: A `rx_strobe` pulse captures `rx_data` and raises `rx_ready` and status bit 1. A data read clears them. A character arriving while the buffer is still full sets the overrun flag in status bit 4.
- R10: Status bit 2 follows `tx_empty`, and bit 6 follows `syn_brk`. Bit 7 is the inverse of `dsr_n`. Bit 3 is sticky on `err_parity`, and bit 5 is sticky on `err_frame`.
- R11: A command with bit 4 set clears status bits 3, 4 and 5. Bit 4 is not kept in the command word.
- R12: A command with bit 6 set clears the command word, which releases `dtr_n`, `rts_n` and `tx_enable`. The next control write is then taken as a new mode word.
- R13: A strobe held low for many cycles acts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_ctl | input | 1 | 1: control/status side, 0: data side |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, 0 when not reading |
| oe_n | output | 1 | Output enable for dout, active low |
| dsr_n | input | 1 | Data set ready, active low |
| cts_n | input | 1 | Clear to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| tx_enable | output | 1 | Transmitter may run |
| mode_word | output | 8 | Stored mode instruction |
| tx_data | output | 8 | Transmit buffer contents |
| tx_valid | output | 1 | Transmit buffer holds a character |
| tx_accept | input | 1 | Transmit engine took the character (pulse) |
| tx_empty | input | 1 | Transmit shifter idle |
| rx_data | input | 8 | Character from the receive engine |
| rx_strobe | input | 1 | Receive engine delivers rx_data (pulse) |
| rx_ready | output | 1 | Receive buffer holds an unread character |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| syn_brk | input | 1 | Sync or break detected |

## Verification
The assertions assume that `sel_ctl` and `din` stay steady for the whole time a strobe is low, plus the synchroniser depth. They also assume that `rx_strobe`, `tx_accept` and the error pulses are synchronous to `clk`. The bench meets this by setting `sel_ctl` and `din` before it lowers a strobe and keeping them until several cycles after release. It drives every engine-side pulse for exactly one cycle, between clock edges. Strobes are held for at least six cycles and are separated by at least six idle cycles, so the two-stage synchroniser never drops an access.

// File: rtl/hif_pkg.sv
package hif_pkg;

   localparam int unsigned BYTE_W = 8;

   // command word bit positions
   localparam int CMD_TXEN   = 0;
   localparam int CMD_DTR    = 1;
   localparam int CMD_ERRCLR = 4;
   localparam int CMD_RTS    = 5;
   localparam int CMD_IRESET = 6;

   // status word bit positions
   localparam int ST_TXRDY  = 0;
   localparam int ST_RXRDY  = 1;
   localparam int ST_TXEMP  = 2;
   localparam int ST_PAR    = 3;
   localparam int ST_OVR    = 4;
   localparam int ST_FRM    = 5;
   localparam int ST_SYNBRK = 6;
   localparam int ST_DSR    = 7;

   typedef enum logic {
      PH_MODE = 1'b0,
      PH_CMD  = 1'b1
   } phase_e;

   typedef struct packed {
      logic frame;
      logic overrun;
      logic parity;
   } err_t;

endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic sel,
   output logic rd_act,
   output logic rd_fire,
   output logic wr_fire,
   output logic sel_s
);

   localparam int unsigned NSIG = 4;
   localparam logic [NSIG-1:0] IDLE = 4'b0111; // sel, cs_n, rd_n, wr_n

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] synced;
   logic            wr_act;
   logic            rd_q;
   logic            wr_q;

   assign raw = {sel, cs_n, rd_n, wr_n};

   if (STAGES > 4) begin : g_bad_stages
      initial $fatal(1, "hif_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign synced = raw;
   end else begin : g_chain
      logic [NSIG-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) chain[i] <= IDLE;
         end else begin
            chain[0] <= raw;
            for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
         end
      end
      assign synced = chain[STAGES-1];
   end

   assign sel_s  = synced[3];
   assign rd_act = ~synced[2] & ~synced[1];
   assign wr_act = ~synced[2] & ~synced[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= rd_act;
         wr_q <= wr_act;
      end
   end

   assign rd_fire = rd_act & ~rd_q;
   assign wr_fire = wr_act & ~wr_q;

   // R13: one action per strobe assertion
   a_r13_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wr_fire);
   a_r13_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> !rd_fire);

endmodule

// File: rtl/hif_regs.sv
module hif_regs
   import hif_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic              wr_fire,
   input  logic              sel_s,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_strobe,
   input  logic              tx_accept,
   input  logic              err_parity,
   input  logic              err_frame,
   input  logic              cts_n,
   output logic [DATA_W-1:0] mode_word,
   output logic [DATA_W-1:0] cmd_word,
   output logic [DATA_W-1:0] tx_buf,
   output logic              tx_full,
   output logic [DATA_W-1:0] rx_buf,
   output logic              rx_full,
   output err_t              err,
   output logic              tx_enable
);

   localparam logic [DATA_W-1:0] CMD_KEEP =
      ~((DATA_W'(1) << CMD_ERRCLR) | (DATA_W'(1) << CMD_IRESET));

   phase_e phase;
   logic   ctl_wr;
   logic   dat_wr;
   logic   dat_rd;
   logic   cmd_wr;
   logic   err_clr;
   logic   ovr_hit;

   assign ctl_wr  = wr_fire &  sel_s;
   assign dat_wr  = wr_fire & ~sel_s;
   assign dat_rd  = rd_fire & ~sel_s;
   assign cmd_wr  = ctl_wr & (phase == PH_CMD);
   assign err_clr = cmd_wr & din[CMD_ERRCLR];
   assign ovr_hit = rx_strobe & rx_full & ~dat_rd;

   // mode / command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_MODE;
         mode_word <= '0;
         cmd_word  <= '0;
      end else if (ctl_wr) begin
         if (phase == PH_MODE) begin
            mode_word <= din;
            phase     <= PH_CMD;
         end else if (din[CMD_IRESET]) begin
            cmd_word  <= '0;
            phase     <= PH_MODE;
         end else begin
            cmd_word  <= din & CMD_KEEP;
         end
      end
   end

   // sticky error flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= '0;
      end else begin
         err.parity  <= (err.parity  & ~err_clr) | err_parity;
         err.frame   <= (err.frame   & ~err_clr) | err_frame;
         err.overrun <= (err.overrun & ~err_clr) | ovr_hit;
      end
   end

   // receive holding buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf  <= '0;
         rx_full <= 1'b0;
      end else if (rx_strobe) begin
         rx_buf  <= rx_data;
         rx_full <= 1'b1;
      end else if (dat_rd) begin
         rx_full <= 1'b0;
      end
   end

   // transmit holding buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf  <= '0;
         tx_full <= 1'b0;
      end else if (dat_wr) begin
         tx_buf  <= din;
         tx_full <= 1'b1;
      end else if (tx_accept) begin
         tx_full <= 1'b0;
      end
   end

   assign tx_enable = cmd_word[CMD_TXEN] & ~cts_n;

   // R9: capture and clear of the receive buffer
   a_r9_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> (rx_full && rx_buf == $past(rx_data)));
   a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && !rx_strobe) |=> !rx_full);
   // R12: internal reset empties the command word
   a_r12_ireset: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && din[CMD_IRESET]) |=> (cmd_word == '0));
   // R11: bit 4 never stays in the command word
   a_r11_no_keep: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> !cmd_word[CMD_ERRCLR]);

endmodule

// File: rtl/hif_status.sv
module hif_status
   import hif_pkg::*;
(
   input  logic              tx_full,
   input  logic              rx_full,
   input  logic              tx_empty,
   input  err_t              err,
   input  logic              syn_brk,
   input  logic              dsr_n,
   output logic [BYTE_W-1:0] status
);

   always_comb begin
      status            = '0;
      status[ST_TXRDY]  = ~tx_full;
      status[ST_RXRDY]  = rx_full;
      status[ST_TXEMP]  = tx_empty;
      status[ST_PAR]    = err.parity;
      status[ST_OVR]    = err.overrun;
      status[ST_FRM]    = err.frame;
      status[ST_SYNBRK] = syn_brk;
      status[ST_DSR]    = ~dsr_n;
   end

endmodule

// File: rtl/usart_host_if.sv
module usart_host_if
   import hif_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              sel_ctl,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              oe_n,
   input  logic              dsr_n,
   input  logic              cts_n,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              tx_enable,
   output logic [DATA_W-1:0] mode_word,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_accept,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_strobe,
   output logic              rx_ready,
   input  logic              err_parity,
   input  logic              err_frame,
   input  logic              syn_brk
);

   if (DATA_W != BYTE_W) begin : g_bad_width
      initial $fatal(1, "usart_host_if: DATA_W must equal 8");
   end

   logic              rd_act;
   logic              rd_fire;
   logic              wr_fire;
   logic              sel_s;
   logic [DATA_W-1:0] cmd_word;
   logic [DATA_W-1:0] rx_buf;
   logic              rx_full;
   logic              tx_full;
   err_t              err;
   logic [BYTE_W-1:0] status;

   hif_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .sel     (sel_ctl),
      .rd_act  (rd_act),
      .rd_fire (rd_fire),
      .wr_fire (wr_fire),
      .sel_s   (sel_s)
   );

   hif_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_fire    (rd_fire),
      .wr_fire    (wr_fire),
      .sel_s      (sel_s),
      .din        (din),
      .rx_data    (rx_data),
      .rx_strobe  (rx_strobe),
      .tx_accept  (tx_accept),
      .err_parity (err_parity),
      .err_frame  (err_frame),
      .cts_n      (cts_n),
      .mode_word  (mode_word),
      .cmd_word   (cmd_word),
      .tx_buf     (tx_data),
      .tx_full    (tx_full),
      .rx_buf     (rx_buf),
      .rx_full    (rx_full),
      .err        (err),
      .tx_enable  (tx_enable)
   );

   hif_status u_status (
      .tx_full  (tx_full),
      .rx_full  (rx_full),
      .tx_empty (tx_empty),
      .err      (err),
      .syn_brk  (syn_brk),
      .dsr_n    (dsr_n),
      .status   (status)
   );

   assign dout     = rd_act ? (sel_s ? status : rx_buf) : '0;
   assign oe_n     = ~rd_act;
   assign dtr_n    = ~cmd_word[CMD_DTR];
   assign rts_n    = ~cmd_word[CMD_RTS];
   assign tx_valid = tx_full;
   assign rx_ready = rx_full;

   // R7: no transmit enable without clear-to-send
   a_r7_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
      cts_n |-> !tx_enable);
   // R3: the bus is quiet while the output enable is off
   a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (dout == '0));
   // R6: modem pins move only after a control write
   a_r6_dtr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dtr_n) |-> $past(wr_fire && sel_s));
   a_r6_rts_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rts_n) |-> $past(wr_fire && sel_s));

endmodule

// File: tb/test_usart_host_if.sv
module test_usart_host_if;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_ctl = 1'b0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic       oe_n;
   logic       dsr_n = 1'b1, cts_n = 1'b1;
   logic       dtr_n, rts_n, tx_enable;
   logic [7:0] mode_word, tx_data;
   logic       tx_valid;
   logic       tx_accept = 1'b0, tx_empty = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_strobe = 1'b0;
   logic       rx_ready;
   logic       err_parity = 1'b0, err_frame = 1'b0, syn_brk = 1'b0;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   usart_host_if i_usart_host_if (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .sel_ctl(sel_ctl), .din(din), .dout(dout), .oe_n(oe_n),
      .dsr_n(dsr_n), .cts_n(cts_n), .dtr_n(dtr_n), .rts_n(rts_n),
      .tx_enable(tx_enable), .mode_word(mode_word), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_accept(tx_accept), .tx_empty(tx_empty),
      .rx_data(rx_data), .rx_strobe(rx_strobe), .rx_ready(rx_ready),
      .err_parity(err_parity), .err_frame(err_frame), .syn_brk(syn_brk)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic sel, input logic [7:0] d, input logic cs);
      @(negedge clk);
      sel_ctl = sel; din = d;
      @(negedge clk);
      cs_n = cs; wr_n = 1'b0;
      idle(6);
      wr_n = 1'b1; cs_n = 1'b1;
      idle(6);
   endtask

   task automatic host_read(input logic sel, input logic cs,
                            output logic [7:0] d, output logic oe);
      @(negedge clk);
      sel_ctl = sel;
      @(negedge clk);
      cs_n = cs; rd_n = 1'b0;
      idle(5);
      d = dout; oe = oe_n;
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b1;
      idle(6);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
      idle(2);
   endtask

   task automatic t_reset;
      chk("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
      chk("R1 rts_n", {7'd0, rts_n}, 8'h01);
      chk("R1 tx_enable", {7'd0, tx_enable}, 8'h00);
      chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
      chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
      chk("R1 oe_n", {7'd0, oe_n}, 8'h01);
      chk("R1 dout", dout, 8'h00);
   endtask

   task automatic t_mode_cmd;
      host_write(1'b1, 8'h4E, 1'b0);
      chk("R5 mode stored", mode_word, 8'h4E);
      chk("R5 first write not a command", {7'd0, dtr_n}, 8'h01);
      host_write(1'b1, 8'h23, 1'b0);
      chk("R6 dtr low", {7'd0, dtr_n}, 8'h00);
      chk("R6 rts low", {7'd0, rts_n}, 8'h00);
      chk("R5 mode kept", mode_word, 8'h4E);
      chk("R7 cts high blocks", {7'd0, tx_enable}, 8'h00);
      cts_n = 1'b0; idle(1);
      chk("R7 enabled", {7'd0, tx_enable}, 8'h01);
      host_write(1'b1, 8'h20, 1'b0);
      chk("R7 bit0 clear blocks", {7'd0, tx_enable}, 8'h00);
      chk("R6 dtr released", {7'd0, dtr_n}, 8'h01);
      chk("R6 rts held", {7'd0, rts_n}, 8'h00);
      cts_n = 1'b1;
   endtask

   task automatic t_gating;
      logic [7:0] d; logic oe;
      host_write(1'b1, 8'h02, 1'b1);
      chk("R2 write ignored without cs", {7'd0, dtr_n}, 8'h01);
      host_read(1'b1, 1'b1, d, oe);
      chk("R2 read ignored without cs (oe)", {7'd0, oe}, 8'h01);
      chk("R3 dout quiet", d, 8'h00);
   endtask

   task automatic t_status;
      logic [7:0] d; logic oe;
      tx_empty = 1'b1; syn_brk = 1'b1; dsr_n = 1'b0;
      host_read(1'b1, 1'b0, d, oe);
      chk("R3 oe during read", {7'd0, oe}, 8'h00);
      chk("R10 status pins set", d, 8'hC5);
      tx_empty = 1'b0; syn_brk = 1'b0; dsr_n = 1'b1;
      host_read(1'b1, 1'b0, d, oe);
      chk("R4 status idle", d, 8'h01);
      chk("R3 oe after read", {7'd0, oe_n}, 8'h01);
   endtask

   task automatic t_rx;
      logic [7:0] d; logic oe;
      rx_data = 8'hA5; pulse(rx_strobe);
      chk("R9 rx_ready set", {7'd0, rx_ready}, 8'h01);
      host_read(1'b1, 1'b0, d, oe);
      chk("R9 status bit1", d, 8'h03);
      rx_data = 8'h3C; pulse(rx_strobe);
      host_read(1'b1, 1'b0, d, oe);
      chk("R9 overrun bit4", d, 8'h13);
      pulse(err_parity); pulse(err_frame);
      host_read(1'b1, 1'b0, d, oe);
      chk("R10 sticky parity/frame", d, 8'h3B);
      host_write(1'b1, 8'h10, 1'b0);
      host_read(1'b1, 1'b0, d, oe);
      chk("R11 errors cleared", d, 8'h03);
      host_read(1'b0, 1'b0, d, oe);
      chk("R4 data read", d, 8'h3C);
      chk("R9 rx_ready cleared", {7'd0, rx_ready}, 8'h00);
   endtask

   task automatic t_tx;
      logic [7:0] d; logic oe;
      host_write(1'b0, 8'h5A, 1'b0);
      chk("R8 tx_valid", {7'd0, tx_valid}, 8'h01);
      chk("R8 tx_data", tx_data, 8'h5A);
      host_read(1'b1, 1'b0, d, oe);
      chk("R8 status bit0 low", d, 8'h00);
      pulse(tx_accept);
      chk("R8 tx_valid cleared", {7'd0, tx_valid}, 8'h00);
   endtask

   task automatic t_single;
      @(negedge clk);
      sel_ctl = 1'b0; din = 8'h99;
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0;
      idle(8);
      tx_accept = 1'b1;
      @(negedge clk);
      tx_accept = 1'b0;
      idle(20);
      chk("R13 long strobe acts once", {7'd0, tx_valid}, 8'h00);
      wr_n = 1'b1; cs_n = 1'b1;
      idle(6);
      chk("R13 no action on release", {7'd0, tx_valid}, 8'h00);
   endtask

   task automatic t_ireset;
      host_write(1'b1, 8'h22, 1'b0);
      chk("R6 dtr low again", {7'd0, dtr_n}, 8'h00);
      host_write(1'b1, 8'h40, 1'b0);
      chk("R12 dtr released", {7'd0, dtr_n}, 8'h01);
      chk("R12 rts released", {7'd0, rts_n}, 8'h01);
      host_write(1'b1, 8'h77, 1'b0);
      chk("R12 next write is mode", mode_word, 8'h77);
      chk("R12 mode write leaves pins", {7'd0, dtr_n}, 8'h01);
      host_write(1'b1, 8'h02, 1'b0);
      chk("R12 command after new mode", {7'd0, dtr_n}, 8'h00);
   endtask

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(3);
      t_reset();
      t_mode_cmd();
      t_gating();
      t_status();
      t_rx();
      t_tx();
      t_single();
      t_ireset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule